// File: doc/BRIEF.md
# Asynchronous Multiplexed Static-Memory Access Sequencer

This block runs one asynchronous read or write cycle on an external NOR-type memory whose address and data share one set of pins. A request port supplies the address, write data, direction and byte-lane enables. The block then steps through four timed phases: address setup, address hold, data and bus turnaround. During these phases it drives chip select, an address-valid strobe, output enable, write enable, the active-low byte-lane selects and the shared address/data bus.

Each phase length comes from a programmable field, and the fields are captured when the request is accepted. For the same field value, a read data phase is two cycles longer than a write data phase. An optional memory wait input, whose active level is programmable, can stretch the data phase only. While wait is active, the data-phase countdown freezes. After the last active wait sample, the data phase always runs for at least four more cycles before data is captured. The read data is returned together with a one-cycle done pulse.

Top module: `smc_async_seq`

## Requirements
- R1: `req_ready` is high when the block is idle. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the last turnaround cycle has completed, and it is high again in the cycle after that.
- R2: The address setup phase starts in the cycle after acceptance and lasts `cfg_addset`+1 cycles. In this phase `mem_cs_n` and `mem_adv_n` are low, `mem_ad_oe` is 1 and `mem_ad_o` equals the request address.
- R3: The address hold phase lasts `cfg_addhld`+1 cycles, and a field value of 0 is treated as 1. In this phase `mem_cs_n` is low, `mem_adv_n` is high, `mem_oe_n` and `mem_we_n` are high, and the address is still driven with `mem_ad_oe` at 1.
- R4: A read data phase lasts `cfg_datast`+3 cycles, and a field value of 0 is treated as 1. In this phase `mem_oe_n` and `mem_cs_n` are low, `mem_we_n` is high and `mem_ad_oe` is 0.
- R5: A write data phase lasts `cfg_datast`+1 cycles, and a field value of 0 is treated as 1. In this phase `mem_we_n` and `mem_cs_n` are low, `mem_oe_n` is high, `mem_ad_oe` is 1 and `mem_ad_o` equals the write data.
- R6: From the first address setup cycle through the last data cycle, `mem_bl_n` equals the inverse of `req_be`. Bit i of `req_be` selects bus bits 8i+7 down to 8i. In every other cycle `mem_bl_n` is all ones.
- R7: The turnaround phase lasts `cfg_busturn`+1 cycles. In this phase, and when idle, `mem_cs_n`, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high and `mem_ad_oe` is 0.
- R8: `mem_ad_i` is sampled in the last data cycle. It appears on `rd_data` in the first turnaround cycle, and `done` is high for exactly that one cycle. `done` also pulses for writes.
- R9: Wait is active when `cfg_wait_en` is 1 and `mem_wait` equals `cfg_wait_pol`. When wait is active in a data cycle, the remaining data-phase count is held instead of decremented, and it is raised to 3 if it is lower. As a result, the last data cycle comes at least 4 cycles after the last active wait sample.
- R10: When `cfg_wait_en` is 0, `mem_wait` has no effect at either level. When `cfg_wait_en` is 1, only the level equal to `cfg_wait_pol` stretches the data phase.
- R11: An active wait during the address setup or address hold phase does not lengthen either phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Address placed on the shared bus |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane enables, active high |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| cfg_addset | input | ASW | Address setup length minus one |
| cfg_addhld | input | HSW | Address hold length minus one |
| cfg_datast | input | DSW | Data phase length field |
| cfg_busturn | input | TSW | Turnaround length minus one |
| cfg_wait_en | input | 1 | Enables the wait input |
| cfg_wait_pol | input | 1 | Active level of the wait input |
| mem_wait | input | 1 | Memory wait |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | DW/8 | Byte-lane selects, active low |
| mem_ad_o | output | DW | Shared bus output value |
| mem_ad_oe | output | 1 | Shared bus output drive enable |
| mem_ad_i | input | DW | Shared bus input value |

## Verification
The embedded properties check a fixed set of rules on every cycle:
- output enable is never asserted while the bus is driven, and output enable and write enable are never asserted together;
- the address strobe is only asserted under chip select;
- `done` is a single-cycle pulse that falls in turnaround;
- `req_ready` drops after acceptance;
- the address phases hand over on count expiry whatever wait does;
- an active wait leaves at least three further data cycles.

Only the directed scenarios can show exact phase lengths for given field values, the clamping of zero fields, the read/write difference in data length, the cycle in which read data is captured, and the stretch produced by a given wait pattern under each polarity and enable setting.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASET = 3'd1,
    PH_AHLD = 3'd2,
    PH_DATA = 3'd3,
    PH_TURN = 3'd4
  } smc_phase_e;
endpackage

// File: rtl/smc_phase_ctl.sv
module smc_phase_ctl
  import smc_pkg::*;
#(
  parameter int ASW = 4,
  parameter int HSW = 4,
  parameter int DSW = 8,
  parameter int TSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           wr_i,
  input  logic [ASW-1:0] addset_i,
  input  logic [HSW-1:0] addhld_i,
  input  logic [DSW-1:0] datast_i,
  input  logic [TSW-1:0] busturn_i,
  input  logic           wait_en_i,
  input  logic           wait_pol_i,
  input  logic           mem_wait_i,
  output smc_phase_e     phase_o,
  output logic           wr_o,
  output logic           data_last_o
);
  localparam int CW = DSW + 2;
  localparam logic [CW-1:0] WAIT_FLOOR = CW'(3);

  smc_phase_e     phase_q, phase_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cfg_ld;
  logic           wr_q, wen_q, wpol_q;
  logic [HSW-1:0] hld_q;
  logic [DSW-1:0] dst_q;
  logic [TSW-1:0] turn_q;
  logic [HSW-1:0] hld_eff;
  logic [DSW-1:0] dst_eff;
  logic           wait_act, cnt_zero;

  assign hld_eff  = (hld_q == '0) ? HSW'(1) : hld_q;
  assign dst_eff  = (dst_q == '0) ? DSW'(1) : dst_q;
  assign cnt_zero = (cnt_q == '0);
  assign wait_act = (phase_q == PH_DATA) && wen_q && (mem_wait_i == wpol_q);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cfg_ld  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_ASET;
        cnt_d   = CW'(addset_i);
        cfg_ld  = 1'b1;
      end
      PH_ASET: if (cnt_zero) begin
        phase_d = PH_AHLD;
        cnt_d   = CW'(hld_eff);
      end else cnt_d = cnt_q - CW'(1);
      PH_AHLD: if (cnt_zero) begin
        phase_d = PH_DATA;
        cnt_d   = wr_q ? CW'(dst_eff) : CW'(dst_eff) + CW'(2);
      end else cnt_d = cnt_q - CW'(1);
      PH_DATA: if (wait_act) begin
        cnt_d = (cnt_q < WAIT_FLOOR) ? WAIT_FLOOR : cnt_q;
      end else if (cnt_zero) begin
        phase_d = PH_TURN;
        cnt_d   = CW'(turn_q);
      end else cnt_d = cnt_q - CW'(1);
      PH_TURN: if (cnt_zero) phase_d = PH_IDLE;
               else cnt_d = cnt_q - CW'(1);
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wen_q  <= 1'b0;
      wpol_q <= 1'b0;
      hld_q  <= '0;
      dst_q  <= '0;
      turn_q <= '0;
    end else if (cfg_ld) begin
      wr_q   <= wr_i;
      wen_q  <= wait_en_i;
      wpol_q <= wait_pol_i;
      hld_q  <= addhld_i;
      dst_q  <= datast_i;
      turn_q <= busturn_i;
    end
  end

  assign phase_o     = phase_q;
  assign wr_o        = wr_q;
  assign data_last_o = (phase_q == PH_DATA) && !wait_act && cnt_zero;

  // R11
  addr_hold_wait_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_AHLD && cnt_zero) |=> (phase_q == PH_DATA));

  // R11
  addr_setup_wait_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ASET && cnt_zero) |=> (phase_q == PH_AHLD));

  // R9
  wait_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_act |=> (phase_q == PH_DATA && cnt_q >= WAIT_FLOOR));
endmodule

// File: rtl/smc_bus_drv.sv
module smc_bus_drv
  import smc_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] be_i,
  input  smc_phase_e    phase_i,
  input  logic          wr_i,
  input  logic          data_last_i,
  input  logic [DW-1:0] mem_ad_i,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [BW-1:0] mem_bl_n,
  output logic [DW-1:0] mem_ad_o,
  output logic          mem_ad_oe,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o
);
  logic [DW-1:0] addr_q, wdata_q, rd_q;
  logic [BW-1:0] be_q;
  logic          done_q, cap_en;
  logic          in_addr, in_data, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  assign cap_en = data_last_i && !wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (cap_en) rd_q <= mem_ad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= data_last_i;
  end

  assign in_addr = (phase_i == PH_ASET) || (phase_i == PH_AHLD);
  assign in_data = (phase_i == PH_DATA);
  assign active  = in_addr || in_data;

  assign mem_cs_n  = !active;
  assign mem_adv_n = (phase_i != PH_ASET);
  assign mem_oe_n  = !(in_data && !wr_i);
  assign mem_we_n  = !(in_data && wr_i);
  assign mem_bl_n  = active ? ~be_q : '1;
  assign mem_ad_o  = in_data ? wdata_q : addr_q;
  assign mem_ad_oe = in_addr || (in_data && wr_i);
  assign rd_data_o = rd_q;
  assign done_o    = done_q;

  // R4
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ad_oe);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R2
  adv_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase_i == PH_TURN) ##1 !done_o);
endmodule

// File: rtl/smc_async_seq.sv
module smc_async_seq
  import smc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int ASW = 4,
  parameter int HSW = 4,
  parameter int DSW = 8,
  parameter int TSW = 4,
  localparam int BW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [DW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BW-1:0]  req_be,
  output logic           done,
  output logic [DW-1:0]  rd_data,
  input  logic [ASW-1:0] cfg_addset,
  input  logic [HSW-1:0] cfg_addhld,
  input  logic [DSW-1:0] cfg_datast,
  input  logic [TSW-1:0] cfg_busturn,
  input  logic           cfg_wait_en,
  input  logic           cfg_wait_pol,
  input  logic           mem_wait,
  output logic           mem_cs_n,
  output logic           mem_adv_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic [BW-1:0]  mem_bl_n,
  output logic [DW-1:0]  mem_ad_o,
  output logic           mem_ad_oe,
  input  logic [DW-1:0]  mem_ad_i
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  smc_phase_e phase;
  logic       wr, data_last, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  smc_phase_ctl #(.ASW(ASW), .HSW(HSW), .DSW(DSW), .TSW(TSW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start),
    .wr_i       (req_write),
    .addset_i   (cfg_addset),
    .addhld_i   (cfg_addhld),
    .datast_i   (cfg_datast),
    .busturn_i  (cfg_busturn),
    .wait_en_i  (cfg_wait_en),
    .wait_pol_i (cfg_wait_pol),
    .mem_wait_i (mem_wait),
    .phase_o    (phase),
    .wr_o       (wr),
    .data_last_o(data_last)
  );

  smc_bus_drv #(.DW(DW), .BW(BW)) u_drv (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start),
    .addr_i     (req_addr),
    .wdata_i    (req_wdata),
    .be_i       (req_be),
    .phase_i    (phase),
    .wr_i       (wr),
    .data_last_i(data_last),
    .mem_ad_i   (mem_ad_i),
    .mem_cs_n   (mem_cs_n),
    .mem_adv_n  (mem_adv_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_bl_n   (mem_bl_n),
    .mem_ad_o   (mem_ad_o),
    .mem_ad_oe  (mem_ad_oe),
    .rd_data_o  (rd_data),
    .done_o     (done)
  );

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/smc_async_seq_tb.sv
module smc_async_seq_tb;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write, done;
  logic [15:0] req_addr, req_wdata, rd_data, mem_ad_o, mem_ad_i;
  logic [1:0]  req_be, mem_bl_n;
  logic [3:0]  cfg_addset, cfg_addhld, cfg_busturn;
  logic [7:0]  cfg_datast;
  logic        cfg_wait_en, cfg_wait_pol, mem_wait;
  logic        mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe;

  int checks = 0, fails = 0;
  bit finished = 0;
  int n_aset, n_ahld, n_data, n_turn, last_data, done_at, bus_err, bl_err, rdy_err;

  smc_async_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .done(done), .rd_data(rd_data), .cfg_addset(cfg_addset), .cfg_addhld(cfg_addhld),
    .cfg_datast(cfg_datast), .cfg_busturn(cfg_busturn), .cfg_wait_en(cfg_wait_en),
    .cfg_wait_pol(cfg_wait_pol), .mem_wait(mem_wait), .mem_cs_n(mem_cs_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n),
    .mem_ad_o(mem_ad_o), .mem_ad_oe(mem_ad_oe), .mem_ad_i(mem_ad_i));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_access(input logic wr, input logic [15:0] addr, input logic [15:0] wdata,
                            input logic [1:0] be, input int aset, input int hld, input int dst,
                            input int bt, input logic wen, input logic wpol, input logic pre,
                            input int wfrom, input int wto, input logic lin, input logic lout);
    int c, dj;
    logic is_d, is_a, is_h;
    @(negedge clk);
    cfg_addset = 4'(aset); cfg_addhld = 4'(hld); cfg_datast = 8'(dst); cfg_busturn = 4'(bt);
    cfg_wait_en = wen; cfg_wait_pol = wpol; mem_wait = pre ? lin : lout;
    req_write = wr; req_addr = addr; req_wdata = wdata; req_be = be; req_valid = 1'b1;
    chk("R1", "ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    n_aset = 0; n_ahld = 0; n_data = 0; n_turn = 0; last_data = -1; done_at = -1;
    bus_err = 0; bl_err = 0; rdy_err = 0; c = 0; dj = 0;
    while (!req_ready && c < 2000) begin
      is_d = !mem_oe_n || !mem_we_n;
      is_a = !is_d && !mem_cs_n && !mem_adv_n;
      is_h = !is_d && !mem_cs_n && mem_adv_n;
      mem_wait = lout;
      if (is_d && dj >= wfrom && dj < wto) mem_wait = lin;
      if ((is_a || is_h) && pre) mem_wait = lin;
      mem_ad_i = 16'hA000 + 16'(dj);
      if (is_a || is_h) begin
        if (!mem_ad_oe || mem_ad_o != addr) bus_err++;
        if (mem_bl_n != ~be) bl_err++;
        if (!mem_oe_n || !mem_we_n) bus_err++;
      end else if (is_d) begin
        if (wr && (!mem_ad_oe || mem_ad_o != wdata || !mem_oe_n)) bus_err++;
        if (!wr && (mem_ad_oe || !mem_we_n)) bus_err++;
        if (mem_bl_n != ~be) bl_err++;
      end else begin
        if (mem_ad_oe || !mem_cs_n || !mem_adv_n) bus_err++;
        if (mem_bl_n != 2'b11) bl_err++;
      end
      if (is_a) n_aset++;
      if (is_h) n_ahld++;
      if (is_d) begin n_data++; last_data = c; dj++; end
      if (!is_a && !is_h && !is_d) n_turn++;
      if (done) done_at = c;
      c++;
      @(negedge clk);
    end
    mem_wait = lout;
    chk("R1", "ready returns", int'(req_ready), 1);
  endtask

  task automatic check_shape(input string tag, input int ea, input int eh, input int ed,
                             input int et, input logic wr, input logic [1:0] be);
    chk("R2", {tag, " setup cycles"}, n_aset, ea);
    chk("R3", {tag, " hold cycles"}, n_ahld, eh);
    chk(wr ? "R5" : "R4", {tag, " data cycles"}, n_data, ed);
    chk("R7", {tag, " turnaround cycles"}, n_turn, et);
    chk(wr ? "R5" : "R4", {tag, " bus/strobe errors"}, bus_err, 0);
    chk("R6", {tag, " byte lane errors"}, bl_err, 0);
    chk("R8", {tag, " done cycle"}, done_at, last_data + 1);
  endtask

  task automatic t_reset;
    chk("R1", "reset ready", int'(req_ready), 1);
    chk("R7", "reset cs_n", int'(mem_cs_n), 1);
    chk("R7", "reset adv_n", int'(mem_adv_n), 1);
    chk("R7", "reset oe_n/we_n", int'(mem_oe_n & mem_we_n), 1);
    chk("R7", "reset bus drive", int'(mem_ad_oe), 0);
    chk("R8", "reset done", int'(done), 0);
    chk("R6", "reset lanes", int'(mem_bl_n), 3);
  endtask

  task automatic t_write_basic;
    run_access(1'b1, 16'h1234, 16'hBEEF, 2'b01, 2, 1, 2, 1, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    check_shape("write basic", 3, 2, 3, 2, 1'b1, 2'b01);
  endtask

  task automatic t_read_basic;
    run_access(1'b0, 16'h5A5A, 16'h0, 2'b11, 0, 3, 1, 0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    check_shape("read basic", 1, 4, 4, 1, 1'b0, 2'b11);
    chk("R8", "read data sampled in last data cycle", int'(rd_data), 16'hA003);
  endtask

  task automatic t_zero_fields;
    run_access(1'b0, 16'h0F0F, 16'h0, 2'b10, 1, 0, 0, 2, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    check_shape("read zero fields", 2, 2, 4, 3, 1'b0, 2'b10);
    run_access(1'b1, 16'h00F0, 16'hC3C3, 2'b10, 0, 0, 0, 0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    check_shape("write zero fields", 1, 2, 2, 1, 1'b1, 2'b10);
  endtask

  task automatic t_wait_mid;
    // R9 R11: active-high wait during address phases and data cycles 1..3
    run_access(1'b0, 16'h2222, 16'h0, 2'b11, 3, 2, 4, 1, 1'b1, 1'b1, 1'b1, 1, 4, 1'b1, 1'b0);
    check_shape("wait mid + address", 4, 3, 10, 2, 1'b0, 2'b11);
    chk("R11", "setup unaffected by wait", n_aset, 4);
    chk("R9", "read data after stretch", int'(rd_data), 16'hA009);
  endtask

  task automatic t_wait_late;
    run_access(1'b0, 16'h3333, 16'h0, 2'b01, 0, 1, 4, 0, 1'b1, 1'b1, 1'b0, 5, 6, 1'b1, 1'b0);
    check_shape("wait late", 1, 2, 10, 1, 1'b0, 2'b01);
    chk("R9", "capture 4 cycles after last wait", last_data, 1 + 2 + 5 + 4);
  endtask

  task automatic t_wait_write;
    run_access(1'b1, 16'h4444, 16'h7777, 2'b11, 0, 1, 2, 0, 1'b1, 1'b1, 1'b0, 0, 1, 1'b1, 1'b0);
    check_shape("wait write", 1, 2, 5, 1, 1'b1, 2'b11);
  endtask

  task automatic t_polarity;
    run_access(1'b0, 16'h5555, 16'h0, 2'b11, 0, 1, 4, 0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b1, 1'b1);
    chk("R10", "active-low, wait held high: no stretch", n_data, 7);
    run_access(1'b0, 16'h6666, 16'h0, 2'b11, 0, 1, 4, 0, 1'b1, 1'b0, 1'b0, 1, 3, 1'b0, 1'b1);
    chk("R10", "active-low, wait low two cycles", n_data, 9);
  endtask

  task automatic t_wait_disabled;
    run_access(1'b0, 16'h7777, 16'h0, 2'b11, 0, 1, 4, 0, 1'b0, 1'b1, 1'b1, 0, 6, 1'b1, 1'b0);
    chk("R10", "disabled wait ignored", n_data, 7);
    chk("R11", "disabled wait, setup length", n_aset, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_be = '0; cfg_addset = '0; cfg_addhld = '0; cfg_datast = '0; cfg_busturn = '0;
    cfg_wait_en = 1'b0; cfg_wait_pol = 1'b0; mem_wait = 1'b0; mem_ad_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_basic();
    t_read_basic();
    t_zero_fields();
    t_wait_mid();
    t_wait_late();
    t_wait_write();
    t_polarity();
    t_wait_disabled();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule